// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat burst. When either of two active-low address strobes is accepted on a rising clock edge, it captures an external address. The low two bits of that address are the first beat of the burst. Each later cycle with the active-low advance input low steps a 2-bit beat counter. The low bits of the output address are then derived from the captured start bits and the counter. Holding advance high keeps the address where it is, which inserts wait states.

Two beat orders are supported. In interleaved order, the low bits are the start bits XOR the beat count. In linear order, they are the start bits plus the beat count, modulo four. An order-select input chooses between them: high means interleaved, low means linear. The input is treated as static. When the pin is configured as absent, a parameter stands in for a pulled-up input, so the block runs interleaved. The address bits above the counter width are copied from the captured address and never change during a burst. After the fourth beat, further advances wrap back to the starting address.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `cur_addr` is all zeros and `burst_pos` is 0 until the first load.
- R2: A clock edge with `strobe_cpu_n` low loads `ext_addr`. From the next cycle, `cur_addr` equals that address and `burst_pos` is 0.
- R3: A clock edge with `strobe_ctl_n` low loads `ext_addr` in the same way as R2.
- R4: On an edge where a strobe is low, the load takes effect and an advance (`adv_n` low) on that same edge is ignored.
- R5: On an edge with no strobe low and `adv_n` low, `burst_pos` increases by one, modulo 4.
- R6: On an edge with no strobe low and `adv_n` high, `cur_addr` and `burst_pos` keep their values.
- R7: With `order_sel` high (1 = interleaved), `cur_addr[1:0]` equals the start bits XOR `burst_pos`.
- R8: With `order_sel` low (0 = linear), `cur_addr[1:0]` equals (start bits + `burst_pos`) mod 4.
- R9: `cur_addr[ADDR_W-1:2]` changes only on a load edge.
- R10: An advance taken at `burst_pos` = 3 returns `burst_pos` to 0 and the low address bits to the start bits.
- R11: With `MODE_PIN_PRESENT` = 0, the `order_sel` pin is ignored and the order is interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External address captured on a load |
| strobe_cpu_n | input | 1 | Active-low processor-side address strobe |
| strobe_ctl_n | input | 1 | Active-low controller-side address strobe |
| adv_n | input | 1 | Active-low beat advance |
| order_sel | input | 1 | Beat order: 1 interleaved, 0 linear |
| cur_addr | output | ADDR_W | Current burst address |
| burst_pos | output | CNT_W | Beat index within the burst, 0 to 3 |

## Verification
The assertions take the strobe, advance and address inputs to be settled at every rising edge. They also take `order_sel` to be held constant across a burst, because the order properties compare against a start value captured under one order. The bench changes inputs only on falling edges. It changes `order_sel` only just before a fresh load, and then sweeps every start value, several upper-address patterns and mixed advance/wait sequences under both orders.

// File: rtl/burst_pkg.sv
package burst_pkg;
   // Beat ordering selected by the order input (1 = interleaved)
   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } burst_order_e;

   localparam int unsigned BEAT_BITS = 2;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned CNT_W  = 2,
   localparam int unsigned UP_W  = ADDR_W - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [UP_W-1:0]   upper_q,
   output logic [CNT_W-1:0]  start_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
      end else if (load) begin
         upper_q <= ext_addr[ADDR_W-1:CNT_W];
         start_q <= ext_addr[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/burst_step_cnt.sv
module burst_step_cnt #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_q
);
   // A load clears the beat index and takes priority over a step.
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
   import burst_pkg::*;
#(
   parameter int unsigned CNT_W            = 2,
   parameter bit          MODE_PIN_PRESENT = 1'b1,
   parameter bit          MODE_DEFAULT     = 1'b1
) (
   input  logic             order_sel,
   input  logic [CNT_W-1:0] start_bits,
   input  logic [CNT_W-1:0] beat,
   output logic [CNT_W-1:0] low_bits
);
   burst_order_e order_eff;

   generate
      if (MODE_PIN_PRESENT) begin : g_pin
         assign order_eff = burst_order_e'(order_sel);
      end else begin : g_fixed
         // Pin absent: the default models an input pulled to its idle level.
         logic unused_sel;
         assign unused_sel = order_sel;
         assign order_eff  = burst_order_e'(MODE_DEFAULT);
      end
   endgenerate

   always_comb begin
      if (order_eff == ORD_INTERLEAVED)
         low_bits = start_bits ^ beat;
      else
         low_bits = start_bits + beat;
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int unsigned ADDR_W           = 20,
   parameter int unsigned CNT_W            = BEAT_BITS,
   parameter bit          MODE_PIN_PRESENT = 1'b1,
   parameter bit          MODE_DEFAULT     = 1'b1,
   localparam int unsigned UP_W            = ADDR_W - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  burst_pos
);
   generate
      if (CNT_W != BEAT_BITS) begin : g_bad_cnt
         $error("burst_addr_gen: CNT_W must equal %0d", BEAT_BITS);
      end
      if (ADDR_W <= CNT_W) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W must exceed CNT_W");
      end
   endgenerate

   logic             load;
   logic             step;
   logic [UP_W-1:0]  upper_q;
   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] beat_q;
   logic [CNT_W-1:0] low_bits;

   assign load = ~strobe_cpu_n | ~strobe_ctl_n;
   assign step = ~adv_n;

   burst_start_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_start (
      .clk(clk), .rst_n(rst_n), .load(load), .ext_addr(ext_addr),
      .upper_q(upper_q), .start_q(start_q)
   );

   burst_step_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .cnt_q(beat_q)
   );

   burst_seq_map #(
      .CNT_W(CNT_W), .MODE_PIN_PRESENT(MODE_PIN_PRESENT), .MODE_DEFAULT(MODE_DEFAULT)
   ) u_map (
      .order_sel(order_sel), .start_bits(start_q), .beat(beat_q), .low_bits(low_bits)
   );

   assign cur_addr  = {upper_q, low_bits};
   assign burst_pos = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              strobe_cpu_n,
   input logic              strobe_ctl_n,
   input logic              adv_n,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [CNT_W-1:0]  burst_pos
);
   logic ld;
   assign ld = !strobe_cpu_n || !strobe_ctl_n;

   // R2 R3 R4: a load shows the captured address at beat 0
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cur_addr == $past(ext_addr)) && (burst_pos == '0));

   // R5: an advance steps the beat index
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv_n) |=> burst_pos == CNT_W'($past(burst_pos) + 1'b1));

   // R6: wait state holds the address
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_n) |=> $stable(cur_addr) && $stable(burst_pos));

   // R9: upper bits move only on a load
   a_r9_upper: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(cur_addr[ADDR_W-1:CNT_W]));

   // R10: the last beat wraps to beat 0
   a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv_n && burst_pos == '1) |=> burst_pos == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_cpu_n(strobe_cpu_n),
   .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .cur_addr(cur_addr), .burst_pos(burst_pos)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          strobe_cpu_n = 1'b1;
   logic          strobe_ctl_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          order_sel = 1'b1;
   logic [AW-1:0] cur_addr, cur_addr2;
   logic [1:0]    burst_pos, burst_pos2;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   logic [AW-3:0] exp_up = '0;
   logic [1:0]    exp_s = '0;
   logic [1:0]    exp_p = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_cpu_n(strobe_cpu_n),
      .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .order_sel(order_sel),
      .cur_addr(cur_addr), .burst_pos(burst_pos)
   );

   // Pin-absent variant, pin driven to linear to show it is ignored (R11)
   burst_addr_gen #(.ADDR_W(AW), .MODE_PIN_PRESENT(1'b0)) dut2 (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_cpu_n(strobe_cpu_n),
      .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .order_sel(1'b0),
      .cur_addr(cur_addr2), .burst_pos(burst_pos2)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] low_of(input logic m, input logic [1:0] s, input logic [1:0] p);
      return m ? (s ^ p) : 2'(s + p);
   endfunction

   // Drive at a falling edge, clock once, update model, check at next falling edge
   task automatic cyc(input logic cpu_n, input logic ctl_n, input logic a_n,
                      input logic [AW-1:0] addr, input string tag);
      logic [1:0] prev_p;
      strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n; adv_n = a_n; ext_addr = addr;
      @(posedge clk);
      prev_p = exp_p;
      if (!cpu_n || !ctl_n) begin
         exp_up = addr[AW-1:2]; exp_s = addr[1:0]; exp_p = 2'd0;
      end else if (!a_n) begin
         exp_p = 2'(exp_p + 1);
      end
      @(negedge clk);
      check({tag, " pos"}, 32'(burst_pos), 32'(exp_p));
      check({tag, " addr"}, 32'(cur_addr), 32'({exp_up, low_of(order_sel, exp_s, exp_p)}));
      check("R9 upper", 32'(cur_addr[AW-1:2]), 32'(exp_up));
      check("R11 fixed interleaved", 32'(cur_addr2), 32'({exp_up, 2'(exp_s ^ exp_p)}));
      if (cpu_n && ctl_n && !a_n && prev_p == 2'd3)
         check("R10 wrap", 32'(cur_addr[1:0]), 32'(exp_s));
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      logic [AW-3:0] ups [3];
      ups[0] = '0; ups[1] = 6'h2A; ups[2] = 6'h3F;
      repeat (3) @(negedge clk);
      check("R1 reset addr", 32'(cur_addr), 32'd0);
      check("R1 reset pos", 32'(burst_pos), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release addr", 32'(cur_addr), 32'd0);
      check("R1 after release pos", 32'(burst_pos), 32'd0);
      for (int m = 1; m >= 0; m--) begin
         order_sel = logic'(m);
         for (int s = 0; s < 4; s++) begin
            for (int u = 0; u < 3; u++) begin
               logic [AW-1:0] a;
               a = {ups[u], 2'(s)};
               // Alternate strobes; odd u loads with advance low (R4)
               if (s[0]) cyc(1'b1, 1'b0, logic'(u[0] == 0), a, "R3 ctl load");
               else      cyc(1'b0, 1'b1, logic'(u[0] == 0), a, "R2 R4 cpu load");
               for (int k = 0; k < 10; k++) begin
                  if (k % 3 == 2) cyc(1'b1, 1'b1, 1'b1, ~a, "R6 hold");
                  else cyc(1'b1, 1'b1, 1'b0, ~a, m ? "R5 R7 interleaved" : "R5 R8 linear");
               end
            end
         end
      end
      // Both strobes together, with advance, then reload mid-burst
      cyc(1'b0, 1'b0, 1'b0, 8'hC6, "R4 both strobes");
      cyc(1'b1, 1'b1, 1'b0, 8'h00, "R8 step");
      cyc(1'b0, 1'b1, 1'b0, 8'h57, "R2 reload mid-burst");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule